// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small set of hardware tokens that two independent ports use to claim shared resources. Each port sees every token through its own select, write strobe, output enable, address and data buses. A port asks for a token by writing a 0 to it and gives it back by writing a 1. It then reads the token to learn the result: 0 means this port holds the token, and 1 means it does not.

When a port asks for a token that the other port holds, the request is not lost. The token latch records it and moves ownership to the waiting port in the same clock edge at which the holder releases. If both ports ask for a free token on the same edge, the left port wins and the right port's request is kept as pending. Read results go into a per-port output register, so a later change made by the other port cannot disturb a value that has already been read.

Everything is synchronous to one clock with an active-low reset. The block is meant to sit beside a shared memory, with its semaphore select decoded separately from the memory enable.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free, and both read-data outputs hold all ones.
- R2: A port makes a semaphore access only when its select is 1 and its memory enable is 0. If the select is 0, or if select and memory enable are both 1, the access has no effect. The token index is address bits [2:0], and the higher address bits are ignored.
- R3: A write (access with write strobe 1) looks only at data bit 0. A 0 requests the token and a 1 releases it. If the owner writes 0 again, nothing changes.
- R4: The port that owns a token reads 0 on every data bit, and the other port reads all ones. A free token reads all ones on both ports.
- R5: While one port owns a token, a 0 written by the other port changes neither port's view.
- R6: When the owner writes 1 and the other port has a pending request, the other port owns the token after that edge. This includes a request made on the same edge as the release. With no pending request, the release leaves the token free.
- R7: A read (access with write strobe 0 and output enable 1) loads the port's output register on the clock edge. The value loaded is the token view from before that edge, copied onto all data bits, and it appears one cycle later. The register holds its value at every other time, including during writes and during reads with output enable 0.
- R8: If both ports request the same free token on the same edge, the left port gets it and the right port's request becomes pending.
- R9: If the port that does not own a token writes 1 to it, that port's pending request is cancelled. A later release then leaves the token free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable (must be 0 for a semaphore access) |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address; bits [2:0] select the token |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read-data register |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read-data register |

## Verification
The bench targets a non-owner's request against a held token. A design that lets it through would show two owners, or would flip the owner's view to 1. It also hits a release on the same edge as the other port's request, where a design that drops the pending bit leaves the token free instead of handing it over. Simultaneous requests on a free token check that exactly the left port wins and that the right port still gets the token after the left one lets go. Further cases are a cancelled request (the token must come back free), illegal accesses with select and memory enable both set (which must not plant a pending request), and reads with output enable low or writes in between (which must leave the read register untouched). A long random phase with heavy address collisions compares both read registers against a behavioural model on every clock.

// File: rtl/sem_token_pkg.sv
package sem_token_pkg;

   typedef enum logic [1:0] {
      TOK_FREE  = 2'd0,
      TOK_LEFT  = 2'd1,
      TOK_RIGHT = 2'd2
   } tok_owner_e;

   // Pending-request update for the port that does not hold the token.
   function automatic logic pend_next(input logic pend, input logic wr_req, input logic wr_rel);
      if (wr_req)      return 1'b1;
      else if (wr_rel) return 1'b0;
      else             return pend;
   endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 9,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               sel,
   input  logic               mem_en,
   input  logic               wr,
   input  logic               oe,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SEM-1:0] req_vec,
   output logic [NUM_SEM-1:0] rel_vec,
   output logic               rd_en,
   output logic [SEL_W-1:0]   idx
);

   logic access;
   logic wr_hit;

   assign access = sel & ~mem_en;
   assign wr_hit = access & wr;
   assign rd_en  = access & ~wr & oe;
   assign idx    = addr[SEL_W-1:0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_onehot
      logic hit;
      assign hit        = wr_hit & (idx == SEL_W'(i));
      assign req_vec[i] = hit & ~wdata[0];
      assign rel_vec[i] = hit &  wdata[0];
   end

   if (ADDR_W > SEL_W) begin : g_addr_sink
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:SEL_W];
   end
   if (DATA_W > 1) begin : g_data_sink
      logic unused_data_hi;
      assign unused_data_hi = ^wdata[DATA_W-1:1];
   end

endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
   import sem_token_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic l_own,
   output logic r_own
);

   tok_owner_e owner_q, owner_d;
   logic       pend_q, pend_d;

   always_comb begin
      owner_d = owner_q;
      pend_d  = pend_q;
      case (owner_q)
         TOK_FREE: begin
            if (l_req) begin
               owner_d = TOK_LEFT;
               pend_d  = r_req;
            end else if (r_req) begin
               owner_d = TOK_RIGHT;
               pend_d  = 1'b0;
            end
         end
         TOK_LEFT: begin
            pend_d = pend_next(pend_q, r_req, r_rel);
            if (l_rel) begin
               owner_d = pend_d ? TOK_RIGHT : TOK_FREE;
               pend_d  = 1'b0;
            end
         end
         TOK_RIGHT: begin
            pend_d = pend_next(pend_q, l_req, l_rel);
            if (r_rel) begin
               owner_d = pend_d ? TOK_LEFT : TOK_FREE;
               pend_d  = 1'b0;
            end
         end
         default: begin
            owner_d = TOK_FREE;
            pend_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= TOK_FREE;
         pend_q  <= 1'b0;
      end else begin
         owner_q <= owner_d;
         pend_q  <= pend_d;
      end
   end

   assign l_own = (owner_q == TOK_LEFT);
   assign r_own = (owner_q == TOK_RIGHT);

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 9,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [SEL_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] own_vec,
   output logic [DATA_W-1:0]  rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '1;
      else if (rd_en) rdata <= {DATA_W{~own_vec[idx]}};
   end

endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_mem_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_sel,
   input  logic              r_mem_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int SEL_W = $clog2(NUM_SEM);

   if (NUM_SEM < 2 || (NUM_SEM & (NUM_SEM - 1)) != 0) begin : g_bad_num
      $error("NUM_SEM must be a power of two, at least 2");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_SEM");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
   logic [NUM_SEM-1:0] l_own, r_own;
   logic               l_rd, r_rd;
   logic [SEL_W-1:0]   l_idx, r_idx;

   sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel(l_sem_sel), .mem_en(l_mem_en), .wr(l_wr), .oe(l_oe),
      .addr(l_addr), .wdata(l_wdata),
      .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd), .idx(l_idx)
   );

   sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel(r_sem_sel), .mem_en(r_mem_en), .wr(r_wr), .oe(r_oe),
      .addr(r_addr), .wdata(r_wdata),
      .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd), .idx(r_idx)
   );

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
      sem_token_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_req(l_req[i]), .l_rel(l_rel[i]),
         .r_req(r_req[i]), .r_rel(r_rel[i]),
         .l_own(l_own[i]), .r_own(r_own[i])
      );
   end

   sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .idx(l_idx),
      .own_vec(l_own), .rdata(l_rdata)
   );

   sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .idx(r_idx),
      .own_vec(r_own), .rdata(r_rdata)
   );

endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               l_sem_sel,
   input logic               l_mem_en,
   input logic               l_wr,
   input logic               l_oe,
   input logic [ADDR_W-1:0]  l_addr,
   input logic [DATA_W-1:0]  l_wdata,
   input logic [DATA_W-1:0]  l_rdata,
   input logic               r_sem_sel,
   input logic               r_mem_en,
   input logic               r_wr,
   input logic               r_oe,
   input logic [ADDR_W-1:0]  r_addr,
   input logic [DATA_W-1:0]  r_wdata,
   input logic [DATA_W-1:0]  r_rdata,
   input logic [NUM_SEM-1:0] l_own,
   input logic [NUM_SEM-1:0] r_own
);

   localparam int SEL_W = $clog2(NUM_SEM);

   logic             l_wacc, r_wacc, l_rdacc, r_rdacc;
   logic [SEL_W-1:0] l_i, r_i;
   logic             l_pick, r_pick;

   assign l_wacc  = l_sem_sel && !l_mem_en && l_wr;
   assign r_wacc  = r_sem_sel && !r_mem_en && r_wr;
   assign l_rdacc = l_sem_sel && !l_mem_en && !l_wr && l_oe;
   assign r_rdacc = r_sem_sel && !r_mem_en && !r_wr && r_oe;
   assign l_i     = l_addr[SEL_W-1:0];
   assign r_i     = r_addr[SEL_W-1:0];
   assign l_pick  = l_own[l_i];
   assign r_pick  = r_own[r_i];

   if (ADDR_W > SEL_W) begin : g_sink
      logic unused_chk_addr;
      assign unused_chk_addr = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W]};
   end
   if (DATA_W > 1) begin : g_dsink
      logic unused_chk_data;
      assign unused_chk_data = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};
   end

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
      logic lq, lr, rq, rr;
      assign lq = l_wacc && (l_i == SEL_W'(i)) && !l_wdata[0];
      assign lr = l_wacc && (l_i == SEL_W'(i)) &&  l_wdata[0];
      assign rq = r_wacc && (r_i == SEL_W'(i)) && !r_wdata[0];
      assign rr = r_wacc && (r_i == SEL_W'(i)) &&  r_wdata[0];

      assert_left_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (l_own[i] && rq && !lr) |=> (l_own[i] && !r_own[i]));
      assert_right_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (r_own[i] && lq && !rr) |=> (r_own[i] && !l_own[i]));
      assert_tie_to_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_own[i] && !r_own[i] && lq && rq) |=> l_own[i]);
      assert_handover_to_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (l_own[i] && lr && rq) |=> r_own[i]);
      assert_handover_to_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (r_own[i] && rr && lq) |=> l_own[i]);
   end

   assert_left_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rdacc |=> $stable(l_rdata));
   assert_right_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rdacc |=> $stable(r_rdata));
   assert_left_rdata_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      l_rdacc |=> (l_rdata == {DATA_W{!$past(l_pick)}}));
   assert_right_rdata_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      r_rdacc |=> (r_rdata == {DATA_W{!$past(r_pick)}}));
   assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && l_mem_en && !r_wacc) |=> ($stable(l_own) && $stable(r_own)));

endmodule

bind sem_token_bank sem_token_bank_chk #(
   .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
   .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
   .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
   .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
   .l_own(l_own), .r_own(r_own)
);

// File: tb/sem_token_bank_tb.sv
`timescale 1ns/1ps
module sem_token_bank_tb;

   localparam int NUM_SEM = 8;
   localparam int ADDR_W  = 15;
   localparam int DATA_W  = 9;
   localparam real CLK_P  = 4.0;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              l_sem_sel, l_mem_en, l_wr, l_oe;
   logic [ADDR_W-1:0] l_addr;
   logic [DATA_W-1:0] l_wdata, l_rdata;
   logic              r_sem_sel, r_mem_en, r_wr, r_oe;
   logic [ADDR_W-1:0] r_addr;
   logic [DATA_W-1:0] r_wdata, r_rdata;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   // model: owner 0 free, 1 left, 2 right
   int                m_own [NUM_SEM];
   bit                m_pend[NUM_SEM];
   logic [DATA_W-1:0] m_l_rd, m_r_rd;

   localparam logic [DATA_W-1:0] ONES  = '1;
   localparam logic [DATA_W-1:0] ZEROS = '0;

   always #(CLK_P/2) clk = ~clk;

   sem_token_bank #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   task automatic check_val(input string rq, input string what,
                            input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic set_l(input logic sel, input logic en, input logic wr, input logic oe,
                        input int a, input logic [DATA_W-1:0] d);
      l_sem_sel = sel; l_mem_en = en; l_wr = wr; l_oe = oe;
      l_addr = ADDR_W'(a); l_wdata = d;
   endtask

   task automatic set_r(input logic sel, input logic en, input logic wr, input logic oe,
                        input int a, input logic [DATA_W-1:0] d);
      r_sem_sel = sel; r_mem_en = en; r_wr = wr; r_oe = oe;
      r_addr = ADDR_W'(a); r_wdata = d;
   endtask

   task automatic idle();
      set_l(0, 0, 0, 0, 0, '0);
      set_r(0, 0, 0, 0, 0, '0);
   endtask

   function automatic void model_step();
      bit la, ra, lw, rw, lrd, rrd;
      int li, ri;
      la  = l_sem_sel && !l_mem_en;
      ra  = r_sem_sel && !r_mem_en;
      lw  = la && l_wr;
      rw  = ra && r_wr;
      lrd = la && !l_wr && l_oe;
      rrd = ra && !r_wr && r_oe;
      li  = int'(l_addr) % NUM_SEM;
      ri  = int'(r_addr) % NUM_SEM;
      if (lrd) m_l_rd = (m_own[li] == 1) ? ZEROS : ONES;
      if (rrd) m_r_rd = (m_own[ri] == 2) ? ZEROS : ONES;
      for (int t = 0; t < NUM_SEM; t++) begin
         bit lq, lr, rq, rr, p;
         lq = lw && li == t && !l_wdata[0];
         lr = lw && li == t &&  l_wdata[0];
         rq = rw && ri == t && !r_wdata[0];
         rr = rw && ri == t &&  r_wdata[0];
         p  = m_pend[t];
         if (m_own[t] == 0) begin
            if (lq) begin m_own[t] = 1; m_pend[t] = rq; end
            else if (rq) begin m_own[t] = 2; m_pend[t] = 0; end
         end else if (m_own[t] == 1) begin
            if (rq) p = 1; else if (rr) p = 0;
            if (lr) begin m_own[t] = p ? 2 : 0; m_pend[t] = 0; end
            else m_pend[t] = p;
         end else begin
            if (lq) p = 1; else if (lr) p = 0;
            if (rr) begin m_own[t] = p ? 1 : 0; m_pend[t] = 0; end
            else m_pend[t] = p;
         end
      end
   endfunction

   task automatic tick(input string rq);
      model_step();
      @(posedge clk);
      #1;
      check_val(rq, "left rdata vs model", l_rdata, m_l_rd);
      check_val(rq, "right rdata vs model", r_rdata, m_r_rd);
      idle();
   endtask

   task automatic wr_l(input string rq, input int a, input logic b);
      set_l(1, 0, 1, 0, a, b ? 9'h001 : 9'h1FE);
      tick(rq);
   endtask

   task automatic wr_r(input string rq, input int a, input logic b);
      set_r(1, 0, 1, 0, a, b ? 9'h001 : 9'h1FE);
      tick(rq);
   endtask

   task automatic expect_view(input string rq, input int idx, input logic lb, input logic rb);
      set_l(1, 0, 0, 1, idx, '0);
      set_r(1, 0, 0, 1, idx, '0);
      tick(rq);
      check_val(rq, "left view", l_rdata, {DATA_W{lb}});
      check_val(rq, "right view", r_rdata, {DATA_W{rb}});
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      idle();
      for (int t = 0; t < NUM_SEM; t++) begin m_own[t] = 0; m_pend[t] = 0; end
      m_l_rd = ONES; m_r_rd = ONES;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check_val("R1", "left rdata after reset", l_rdata, ONES);
      check_val("R1", "right rdata after reset", r_rdata, ONES);
      expect_view("R1", 0, 1, 1);
      expect_view("R1", 7, 1, 1);

      // R3, R4: request with only bit 0 low, owner view
      wr_l("R3", 2, 0);
      expect_view("R4", 2, 0, 1);
      wr_l("R3", 2, 0);               // owner writes 0 again
      expect_view("R3", 2, 0, 1);
      set_l(1, 0, 1, 0, 6, 9'h0FF);   // bit0 = 1 on free token: stays free
      tick("R3");
      expect_view("R3", 6, 1, 1);

      // R5: non-owner request blocked
      wr_r("R5", 2, 0);
      expect_view("R5", 2, 0, 1);

      // R6: release hands over to pending right, then right release frees
      wr_l("R6", 2, 1);
      expect_view("R6", 2, 1, 0);
      wr_r("R6", 2, 1);
      expect_view("R6", 2, 1, 1);
      // R6: same-edge release and request
      wr_r("R6", 1, 0);
      set_r(1, 0, 1, 0, 1, 9'h001);
      set_l(1, 0, 1, 0, 1, 9'h000);
      tick("R6");
      expect_view("R6", 1, 0, 1);
      wr_l("R6", 1, 1);
      expect_view("R6", 1, 1, 1);

      // R2: upper address bits ignored, illegal access ignored
      wr_l("R2", 15'h7FFD, 0);
      expect_view("R2", 5, 0, 1);
      set_r(1, 1, 1, 0, 5, '0);       // select with memory enable: no pending
      tick("R2");
      set_r(0, 0, 1, 0, 5, '0);       // no select: no pending
      tick("R2");
      wr_l("R2", 5, 1);
      expect_view("R2", 5, 1, 1);
      set_l(1, 1, 1, 0, 5, '0);       // illegal request on free token
      tick("R2");
      expect_view("R2", 5, 1, 1);

      // R8: tie on free token goes left, right pending
      set_l(1, 0, 1, 0, 6, '0);
      set_r(1, 0, 1, 0, 6, '0);
      tick("R8");
      expect_view("R8", 6, 0, 1);
      wr_l("R8", 6, 1);
      expect_view("R8", 6, 1, 0);
      wr_r("R8", 6, 1);
      expect_view("R8", 6, 1, 1);

      // R9: cancel of pending request
      wr_l("R9", 3, 0);
      wr_r("R9", 3, 0);
      wr_r("R9", 3, 1);
      wr_l("R9", 3, 1);
      expect_view("R9", 3, 1, 1);

      // R7: read register load and hold
      wr_l("R7", 4, 0);
      expect_view("R7", 4, 0, 1);
      wr_l("R7", 4, 1);               // write does not load rdata
      check_val("R7", "left rdata held over write", l_rdata, ZEROS);
      set_l(1, 0, 0, 0, 4, '0);       // read with oe low: no load
      tick("R7");
      check_val("R7", "left rdata held oe low", l_rdata, ZEROS);
      set_l(1, 0, 0, 1, 4, '0);       // left reads free token
      set_r(1, 0, 1, 0, 4, '0);       // right takes it on same edge
      tick("R7");
      check_val("R7", "left captured pre-edge view", l_rdata, ONES);
      set_r(1, 0, 0, 1, 4, '0);
      tick("R7");
      check_val("R7", "right owner view", r_rdata, ZEROS);
      wr_r("R7", 4, 1);

      // random phase with heavy collisions, model compare every clock
      for (int n = 0; n < 2000; n++) begin
         set_l(($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) != 0,
               int'(($urandom & 32'h7FF8) | ($urandom % 3)), DATA_W'($urandom));
         set_r(($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) != 0,
               int'(($urandom & 32'h7FF8) | ($urandom % 3)), DATA_W'($urandom));
         tick("R4");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule